// File: doc/BRIEF.md
# Windowed Slow-Clock Watchdog

This block guards a system against software that has stopped running. A 12-bit down-counter steps once every 128 periods of a 32768 Hz slow clock, which gives 256 steps per second. The timeout in seconds therefore sets the reload value: 256 times the timeout, minus one, for timeouts from 1 to 16 seconds. If software lets the counter run past zero, the block raises a reset request or a fault interrupt, whichever the mode register selects. Software keeps the counter from expiring by sending a restart command. That command must carry a key, and it is accepted only while the counter has dropped to or below a window limit. A restart sent too early is treated as a fault in the same way as an expiry.

The block runs on the bus clock. It sees the slow clock only as a one-cycle enable pulse, `slow_tick`. Three word registers sit on the bus. Control, at address 0, takes restart commands. Mode, at address 1, holds the reload value, the window limit, the action selects, the disable bit and the halt selects. Status, at address 2, shows the fault flags and the live count, and a read of it clears the flags. After an accepted restart, the control and mode registers ignore writes for three slow-clock periods. While the watchdog is disabled, the reload and window fields cannot be changed.

Top module: `slowclk_wdog`

## Requirements
- R1: After reset, mode reads 32'h0FFF_8FFF (disabled, reload 4095, window 4095, no actions, no halts), status reads 32'h0FFF_0000, and `rst_req` and `fault_irq` are low.
- R2: When enabled and not halted, the count drops by one every 128 `slow_tick` pulses. Starting from a reload to value V, the (V+1)*128-th pulse sets status bit 0 (expiry) and reloads V. Status bits [27:16] show the count.
- R3: A write to control reloads the counter only when bits [31:24] equal 8'hA5 and bit 0 is 1. A write with any other key has no effect.
- R4: For 3 `slow_tick` pulses after an accepted restart, writes to control and mode are ignored.
- R5: While mode bit 15 (disable) is set, the count holds, and mode writes leave the reload field [11:0] and the window field [27:16] unchanged. The other mode bits are still written.
- R6: Every accepted mode write reloads the counter with the reload field as it stands after that write.
- R7: `rst_req` is high while a fault flag is set and mode bit 12 is set. `fault_irq` is high while a fault flag is set and mode bit 13 is set.
- R8: Mode bit 28 stops the counter while `idle_in` is high. Mode bit 29 stops it while `debug_in` is high. Without its mode bit, a halt input has no effect.
- R9: A keyed restart while enabled and with the count above the window field sets status bit 1 (window error). It does not reload the counter and does not start the write lockout. A keyed restart at or below the window reloads normally.
- R10: A read of status clears bits 0 and 1. An event that occurs in the same cycle as the read still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable marking each slow-clock period |
| idle_in | input | 1 | System idle indication |
| debug_in | input | 1 | Debugger halt indication |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears flags) |
| bus_addr | input | 2 | Register select: 0 control, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| rst_req | output | 1 | Reset request to the system reset controller |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The lockout window is the hardest case to reach from the ports. It lasts only three slow-clock periods, so if `slow_tick` fires on every bus cycle the window closes before a second bus write can arrive. The bench therefore slows the tick to one pulse every 16 bus cycles. It then sends a mode write right behind a keyed restart and reads the mode back. After that it lets the ticks run out and repeats the same write. The early-restart fault is reached in a similar way: the bench programs a small window with a larger reload, restarts at once, and then checks that no lockout followed the rejected restart.

// File: rtl/slowclk_wdog.sv
module slowclk_wdog #(
  parameter int          CNT_W     = 12,
  parameter int          PRESCALE  = 128,
  parameter int          LOCK_SLOW = 3,
  parameter logic [7:0]  KEY       = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        idle_in,
  input  logic        debug_in,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req,
  output logic        fault_irq
);
  localparam int PRE_W  = $clog2(PRESCALE);
  localparam int LOCK_W = $clog2(LOCK_SLOW + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [LOCK_W-1:0] LOCK_LD  = LOCK_W'(LOCK_SLOW);

  logic [CNT_W-1:0]  val_q, dlt_q, cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [LOCK_W-1:0] lock_q;
  logic rst_en_q, irq_en_q, dis_q, ihalt_q, dhalt_q, unf_q, err_q;

  wire unlocked    = (lock_q == '0);
  wire wr_ctrl     = bus_wr && bus_addr == 2'd0 && unlocked;
  wire wr_mode     = bus_wr && bus_addr == 2'd1 && unlocked;
  wire rd_stat     = bus_rd && bus_addr == 2'd2;
  wire restart_req = wr_ctrl && bus_wdata[31:24] == KEY && bus_wdata[0];
  wire win_bad     = restart_req && !dis_q && (cnt_q > dlt_q);
  wire restart_ok  = restart_req && !win_bad;
  wire halted      = (ihalt_q && idle_in) || (dhalt_q && debug_in);
  wire running     = !dis_q && !halted;
  wire step        = slow_tick && running && pre_q == PRE_LAST;
  wire underflow   = step && cnt_q == '0;
  wire [CNT_W-1:0] val_nx = dis_q ? val_q : bus_wdata[CNT_W-1:0];
  wire [CNT_W-1:0] dlt_nx = dis_q ? dlt_q : bus_wdata[16 +: CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '1; dlt_q <= '1;
      rst_en_q <= 1'b0; irq_en_q <= 1'b0; dis_q <= 1'b1;
      ihalt_q <= 1'b0; dhalt_q <= 1'b0;
    end else if (wr_mode) begin
      val_q    <= val_nx;
      dlt_q    <= dlt_nx;
      rst_en_q <= bus_wdata[12];
      irq_en_q <= bus_wdata[13];
      dis_q    <= bus_wdata[15];
      ihalt_q  <= bus_wdata[28];
      dhalt_q  <= bus_wdata[29];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      pre_q <= '0;
    end else if (wr_mode || restart_ok) begin
      cnt_q <= wr_mode ? val_nx : val_q;
      pre_q <= '0;
    end else if (slow_tick && running) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (underflow)  cnt_q <= val_q;
      else if (step)  cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      unf_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (restart_ok)                 lock_q <= LOCK_LD;
      else if (slow_tick && !unlocked) lock_q <= lock_q - 1'b1;
      unf_q <= underflow || (unf_q && !rd_stat);
      err_q <= win_bad   || (err_q && !rd_stat);
    end
  end

  logic [31:0] mode_rd, stat_rd;
  always_comb begin
    mode_rd = '0;
    mode_rd[CNT_W-1:0]  = val_q;
    mode_rd[12]         = rst_en_q;
    mode_rd[13]         = irq_en_q;
    mode_rd[15]         = dis_q;
    mode_rd[16 +: CNT_W] = dlt_q;
    mode_rd[28]         = ihalt_q;
    mode_rd[29]         = dhalt_q;
    stat_rd = '0;
    stat_rd[0] = unf_q;
    stat_rd[1] = err_q;
    stat_rd[16 +: CNT_W] = cnt_q;
  end

  assign bus_rdata = (bus_addr == 2'd1) ? mode_rd :
                     (bus_addr == 2'd2) ? stat_rd : 32'd0;
  assign rst_req   = (unf_q || err_q) && rst_en_q;
  assign fault_irq = (unf_q || err_q) && irq_en_q;

  p_expiry_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> unf_q);
  p_bad_key_no_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[31:24] != KEY && unlocked) |=> (lock_q == '0));
  p_mode_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !unlocked) |=> $stable(mode_rd));
  p_fields_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dis_q) |=> ($stable(val_q) && $stable(dlt_q)));
  p_halt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !bus_wr) |=> $stable(cnt_q));
  p_early_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req && !dis_q && cnt_q > dlt_q) |=> (err_q && lock_q == '0));
  p_lock_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q <= LOCK_LD);
endmodule

// File: tb/slowclk_wdog_bench.sv
module slowclk_wdog_bench;
  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, idle_in = 1'b0, debug_in = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata, rd;
  logic rst_req, fault_irq;
  int checks = 0, fails = 0, tick_div = 1, tcnt = 0;

  always #10 clk = ~clk;

  slowclk_wdog u_slowclk_wdog (.clk, .rst_n, .slow_tick, .idle_in, .debug_in,
    .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .rst_req, .fault_irq);

  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) begin slow_tick <= 1'b1; tcnt <= 0; end
    else begin slow_tick <= 1'b0; tcnt <= tcnt + 1; end
  end

  // {write data, expected mode readback}; starts disabled
  localparam logic [63:0] MODE_VEC [6] = '{
    {32'h0003_9005, 32'h0FFF_9FFF},
    {32'h0003_1005, 32'h0FFF_1FFF},
    {32'h0003_1005, 32'h0003_1005},
    {32'h1007_2010, 32'h1007_2010},
    {32'hFFFF_FFFF, 32'h3FFF_BFFF},
    {32'h0000_0001, 32'h0FFF_0FFF}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rst_req && !fault_irq, "R1 outputs", {30'd0, rst_req, fault_irq}, 32'd0);
    bus_read(2'd1, rd); check(rd == 32'h0FFF_8FFF, "R1 mode", rd, 32'h0FFF_8FFF);
    bus_read(2'd2, rd); check(rd == 32'h0FFF_0000, "R1 status", rd, 32'h0FFF_0000);

    for (int i = 0; i < 6; i++) begin
      bus_write(2'd1, MODE_VEC[i][63:32]);
      bus_read(2'd1, rd);
      check(rd == MODE_VEC[i][31:0], "R5 mode table", rd, MODE_VEC[i][31:0]);
    end

    // R2 / R7 expiry with reload 1: flag at the 256th tick
    bus_write(2'd1, 32'h0FFF_1001);
    repeat (255) @(posedge clk);
    @(negedge clk); check(!rst_req, "R2 before expiry", {31'd0, rst_req}, 32'd0);
    @(posedge clk); @(negedge clk);
    check(rst_req && !fault_irq, "R7 reset request", {30'd0, rst_req, fault_irq}, 32'd2);
    bus_read(2'd2, rd); check(rd == 32'h0001_0001, "R2 status after expiry", rd, 32'h0001_0001);
    check(!rst_req, "R10 cleared by read", {31'd0, rst_req}, 32'd0);
    bus_read(2'd2, rd); check(rd == 32'h0001_0000, "R10 second read", rd, 32'h0001_0000);

    bus_write(2'd1, 32'h0FFF_2001);
    repeat (300) @(negedge clk);
    check(fault_irq && !rst_req, "R7 interrupt", {30'd0, rst_req, fault_irq}, 32'd1);
    bus_read(2'd2, rd);

    // R3 key
    bus_write(2'd1, 32'h0FFF_1FFF);
    repeat (400) @(negedge clk);
    bus_write(2'd0, 32'h5A00_0001);
    bus_read(2'd2, rd); check(rd[27:16] < 12'hFFF, "R3 wrong key ignored", rd, 32'h0FFC_0000);
    bus_write(2'd0, 32'hA500_0001);
    bus_read(2'd2, rd); check(rd == 32'h0FFF_0000, "R3 keyed restart", rd, 32'h0FFF_0000);

    // R4 lockout with sparse ticks
    tick_div = 16;
    repeat (40) @(negedge clk);
    bus_write(2'd0, 32'hA500_0001);
    bus_write(2'd1, 32'h0003_1005);
    bus_read(2'd1, rd); check(rd == 32'h0FFF_1FFF, "R4 mode locked", rd, 32'h0FFF_1FFF);
    repeat (80) @(negedge clk);
    bus_write(2'd1, 32'h0003_1005);
    bus_read(2'd1, rd); check(rd == 32'h0003_1005, "R4 unlocked", rd, 32'h0003_1005);
    bus_read(2'd2, rd); check(rd == 32'h0005_0000, "R6 mode write reload", rd, 32'h0005_0000);

    // R9 window
    bus_write(2'd0, 32'hA500_0001);
    check(rst_req, "R9 early restart fault", {31'd0, rst_req}, 32'd1);
    bus_read(2'd2, rd); check(rd == 32'h0005_0002, "R9 no reload", rd, 32'h0005_0002);
    bus_write(2'd1, 32'h0003_1002);
    bus_read(2'd1, rd); check(rd == 32'h0003_1002, "R9 no lockout", rd, 32'h0003_1002);
    bus_write(2'd0, 32'hA500_0001);
    bus_read(2'd2, rd); check(rd == 32'h0002_0000, "R9 in-window restart", rd, 32'h0002_0000);

    // R8 halts
    tick_div = 1;
    repeat (100) @(negedge clk);
    bus_write(2'd1, 32'h1FFF_1FFF);
    idle_in = 1'b1;
    repeat (500) @(negedge clk);
    bus_read(2'd2, rd); check(rd == 32'h0FFF_0000, "R8 idle halt", rd, 32'h0FFF_0000);
    idle_in = 1'b0;
    repeat (300) @(negedge clk);
    bus_read(2'd2, rd); check(rd[27:16] < 12'hFFF && rd[1:0] == 2'b00, "R8 idle released", rd, 32'h0FFD_0000);
    bus_write(2'd1, 32'h2FFF_1FFF);
    debug_in = 1'b1;
    repeat (500) @(negedge clk);
    bus_read(2'd2, rd); check(rd == 32'h0FFF_0000, "R8 debug halt", rd, 32'h0FFF_0000);
    debug_in = 1'b0; idle_in = 1'b1;
    repeat (300) @(negedge clk);
    bus_read(2'd2, rd); check(rd[27:16] < 12'hFFF, "R8 idle without its bit", rd, 32'h0FFD_0000);
    idle_in = 1'b0;

    // R5 disabled holds and freezes
    bus_write(2'd1, 32'h0005_9005);
    repeat (1000) @(negedge clk);
    bus_read(2'd2, rd); check(rd == 32'h0005_0000 && !rst_req, "R5 count held", rd, 32'h0005_0000);
    bus_write(2'd1, 32'h0009_1009);
    bus_read(2'd1, rd); check(rd == 32'h0005_1005, "R5 fields frozen", rd, 32'h0005_1005);

    finish_run();
  end
endmodule